// File: doc/BRIEF.md
# Power-Controller Request and Status Bridge

This block is a small register target on a 32-bit host bus. It passes power-management work from the host to a slow microcontroller port. The host can ask for two kinds of work. The first is a new performance level for one of two CPU clusters. The second is a generic configuration read or write, launched through a command register. Every request that is accepted becomes exactly one transaction on a request/acknowledge port. The block serves one transaction at a time.

When the acknowledge arrives, the block records the outcome in a shared status word. Each request kind owns a pair of bits there, one for completion and one for error. A level interrupt is held high while any status bit is set. The host reads the status word to learn the outcome, and that read clears it.

If the host issues a request while another one is outstanding, the new request is refused at once and flagged as an error for its kind. A read-only register reports how many CPUs each cluster has.

Top module: `pwr_req_bridge`

## Requirements
- R1: After reset the status word, the interrupt, the request output, both cluster levels, the command readback and the read-data register are all zero.
- R2: A bus write to 0xB00 (cluster 0, kind 0) or 0xB08 (cluster 1, kind 1) forwards one transaction with mcKind equal to the kind, mcWrite=1 and mcWdata equal to write bits 2:0. A read of that address keeps returning the old 3-bit level until the transaction completes without error, and returns the new level afterwards.
- R3: A write to the command register 0xB10 with bit 31 set starts a kind-2 transaction. In it, mcWrite is bit 30, mcFunc is bits 25:20 and mcDevice is bits 11:0. mcWdata is the write-data register at 0xB70. A command write with bit 31 clear only stores the fields and forwards nothing.
- R4: Bit 31 of the command readback is 1 while a configuration transaction waits for its acknowledge. It reads 0 from the cycle after the acknowledge. The other readback bits are the stored bits 30, 25:20 and 11:0.
- R5: For a configuration read acknowledged without error, mcRdata appears at 0xB74 one cycle before the completion bit is set.
- R6: The status word sits at 0xB18. For kind t, bit 4t is complete and bit 4t+1 is error. An acknowledge with mcErr high sets the error bit instead of the complete bit. A failed level change leaves the cluster level unchanged.
- R7: irq is high exactly while some status bit is set. A status read returns the word and clears it on that clock edge.
- R8: A request written while another is outstanding sets the error bit of its own kind at that edge. It is not forwarded, and the outstanding transaction continues undisturbed.
- R9: The register at 0x700 reads the cluster-0 CPU count in bits 19:16 and the cluster-1 count in bits 23:20. Its other bits are 0, and unmapped addresses read 0.
- R10: mcReq and its payload (mcKind, mcWrite, mcFunc, mcDevice, mcWdata) stay stable from the edge a request is accepted until the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus access this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 12 | Byte offset |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, same cycle |
| irq | output | 1 | Active-high level interrupt |
| mcReq | output | 1 | Transaction request to the microcontroller |
| mcWrite | output | 1 | Transaction direction |
| mcKind | output | 2 | Request kind 0/1/2 |
| mcFunc | output | 6 | Configuration function code |
| mcDevice | output | 12 | Configuration device number |
| mcWdata | output | 32 | Transaction write data |
| mcAck | input | 1 | One-cycle acknowledge |
| mcErr | input | 1 | Error flag, valid with mcAck |
| mcRdata | input | 32 | Read data, valid with mcAck |

## Verification
A write that makes a request raises mcReq from the edge that accepts the write. A rejection error is visible from that same edge. Captured read data is visible right after the acknowledge edge, and the status bits and irq come one edge later. A status clear takes effect at the edge that ends the read. The bench samples every result at the falling edge that follows the edge where it is due. For R5 it checks the read-data register and a still-low irq in the half cycle between the acknowledge edge and the posting edge. It samples only at falling edges, and status is read over the bus only when clearing is intended.

// File: rtl/pwrb_pkg.sv
package pwrb_pkg;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 12;
  localparam int NUM_KINDS = 3;
  localparam int STAT_W    = 4 * NUM_KINDS;

  localparam logic [ADDR_W-1:0] ADR_LVL0  = 12'hB00;
  localparam logic [ADDR_W-1:0] ADR_LVL1  = 12'hB08;
  localparam logic [ADDR_W-1:0] ADR_CMD   = 12'hB10;
  localparam logic [ADDR_W-1:0] ADR_STAT  = 12'hB18;
  localparam logic [ADDR_W-1:0] ADR_WDATA = 12'hB70;
  localparam logic [ADDR_W-1:0] ADR_RDATA = 12'hB74;
  localparam logic [ADDR_W-1:0] ADR_INFO  = 12'h700;

  localparam int CMD_GO   = 31;
  localparam int CMD_WR   = 30;
  localparam int FUNC_LSB = 20;
  localparam int FUNC_W   = 6;
  localparam int DEV_W    = 12;

  typedef enum logic [1:0] {
    KIND_LVL0 = 2'd0,
    KIND_LVL1 = 2'd1,
    KIND_CFG  = 2'd2
  } reqKind_e;

  // control -> datapath strobes
  typedef struct packed {
    logic     accept;
    logic     reject;
    reqKind_e rejKind;
    logic     capture;
    logic     post;
    logic     postErr;
    reqKind_e postKind;
  } strobes_t;
endpackage

// File: rtl/pwrb_ctrl.sv
module pwrb_ctrl
  import pwrb_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     newReq,
  input  reqKind_e newKind,
  input  logic     mcAck,
  input  logic     mcErr,
  output strobes_t strobes,
  output logic     mcReq,
  output reqKind_e mcKind
);
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_POST} state_e;

  state_e   state;
  reqKind_e curKind;
  logic     errReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      curKind <= KIND_LVL0;
      errReg  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (newReq) begin
          state   <= ST_WAIT;
          curKind <= newKind;
        end
        ST_WAIT: if (mcAck) begin
          state  <= ST_POST;
          errReg <= mcErr;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes.accept   = newReq && (state == ST_IDLE);
    strobes.reject   = newReq && (state != ST_IDLE);
    strobes.rejKind  = newKind;
    strobes.capture  = (state == ST_WAIT) && mcAck;
    strobes.post     = (state == ST_POST);
    strobes.postErr  = errReg;
    strobes.postKind = curKind;
  end

  assign mcReq  = (state == ST_WAIT);
  assign mcKind = curKind;

  // R10: request held with the same kind until acknowledged
  assert_req_held_R10: assert property (@(posedge clk) disable iff (!rstN)
    (mcReq && !mcAck) |=> (mcReq && $stable(mcKind)));

  // R8: nothing is accepted while a transaction is outstanding
  assert_no_accept_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    mcReq |-> !strobes.accept);
endmodule

// File: rtl/pwrb_datapath.sv
module pwrb_datapath
  import pwrb_pkg::*;
#(
  parameter int LEVEL_W = 3,
  parameter int CNT_W   = 4,
  parameter int CPUS0   = 4,
  parameter int CPUS1   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irq,
  output logic              newReq,
  output reqKind_e          newKind,
  input  strobes_t          strobes,
  input  logic              mcReq,
  input  logic              mcAck,
  input  logic              mcErr,
  input  logic [DATA_W-1:0] mcRdata,
  output logic              mcWrite,
  output logic [FUNC_W-1:0] mcFunc,
  output logic [DEV_W-1:0]  mcDevice,
  output logic [DATA_W-1:0] mcWdata
);
  localparam int NUM_CLUSTERS = 2;
  localparam int INFO_LSB     = 16;
  localparam int INFO_PAD     = DATA_W - INFO_LSB - 2 * CNT_W;
  localparam int FUNC_GAP     = CMD_WR - FUNC_LSB - FUNC_W;
  localparam int DEV_GAP      = FUNC_LSB - DEV_W;

  logic wrLvl0, wrLvl1, wrCmd, wrWdata, rdStat;
  assign wrLvl0  = busSel && busWrite && (busAddr == ADR_LVL0);
  assign wrLvl1  = busSel && busWrite && (busAddr == ADR_LVL1);
  assign wrCmd   = busSel && busWrite && (busAddr == ADR_CMD);
  assign wrWdata = busSel && busWrite && (busAddr == ADR_WDATA);
  assign rdStat  = busSel && !busWrite && (busAddr == ADR_STAT);

  assign newReq  = wrLvl0 || wrLvl1 || (wrCmd && busWdata[CMD_GO]);
  assign newKind = wrLvl0 ? KIND_LVL0 : (wrLvl1 ? KIND_LVL1 : KIND_CFG);

  // stored command fields and data registers
  logic              cmdWr, cfgGo;
  logic [FUNC_W-1:0] cmdFunc;
  logic [DEV_W-1:0]  cmdDev;
  logic [DATA_W-1:0] wdataReg, rdataReg;

  // snapshot of the transaction in flight
  reqKind_e          snapKind;
  logic              snapWrite;
  logic [FUNC_W-1:0] snapFunc;
  logic [DEV_W-1:0]  snapDev;
  logic [DATA_W-1:0] snapData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdWr <= 1'b0; cmdFunc <= '0; cmdDev <= '0; cfgGo <= 1'b0;
      wdataReg <= '0; rdataReg <= '0;
      snapKind <= KIND_LVL0; snapWrite <= 1'b0; snapFunc <= '0;
      snapDev <= '0; snapData <= '0;
    end else begin
      if (wrCmd) begin
        cmdWr   <= busWdata[CMD_WR];
        cmdFunc <= busWdata[FUNC_LSB +: FUNC_W];
        cmdDev  <= busWdata[DEV_W-1:0];
      end
      if (wrWdata) wdataReg <= busWdata;
      if (strobes.accept) begin
        snapKind <= newKind;
        if (newKind == KIND_CFG) begin
          snapWrite <= busWdata[CMD_WR];
          snapFunc  <= busWdata[FUNC_LSB +: FUNC_W];
          snapDev   <= busWdata[DEV_W-1:0];
          snapData  <= wdataReg;
          cfgGo     <= 1'b1;
        end else begin
          snapWrite <= 1'b1;
          snapFunc  <= '0;
          snapDev   <= '0;
          snapData  <= {{(DATA_W-LEVEL_W){1'b0}}, busWdata[LEVEL_W-1:0]};
        end
      end
      if (strobes.capture && snapKind == KIND_CFG) begin
        cfgGo <= 1'b0;
        if (!snapWrite && !mcErr) rdataReg <= mcRdata;
      end
    end
  end

  assign mcWrite  = snapWrite;
  assign mcFunc   = snapFunc;
  assign mcDevice = snapDev;
  assign mcWdata  = snapData;

  // per-cluster current level
  logic [LEVEL_W-1:0] levelCur [NUM_CLUSTERS];
  for (genvar c = 0; c < NUM_CLUSTERS; c++) begin : g_level
    always_ff @(posedge clk) begin
      if (!rstN) levelCur[c] <= '0;
      else if (strobes.post && !strobes.postErr && strobes.postKind == 2'(c))
        levelCur[c] <= snapData[LEVEL_W-1:0];
    end
  end

  // status pairs: [0] complete, [1] error
  logic [1:0]        statPair [NUM_KINDS];
  logic [STAT_W-1:0] statusWord;
  logic [NUM_KINDS-1:0] anySetVec;
  for (genvar t = 0; t < NUM_KINDS; t++) begin : g_stat
    logic setDone, setErr;
    assign setDone = strobes.post && !strobes.postErr && strobes.postKind == 2'(t);
    assign setErr  = (strobes.post && strobes.postErr && strobes.postKind == 2'(t))
                   || (strobes.reject && strobes.rejKind == 2'(t));
    assign anySetVec[t] = setDone || setErr;
    always_ff @(posedge clk) begin
      if (!rstN) statPair[t] <= 2'b00;
      else statPair[t] <= (rdStat ? 2'b00 : statPair[t]) | {setErr, setDone};
    end
    assign statusWord[4*t +: 4] = {2'b00, statPair[t]};

    // R8: a refused request flags the error bit of its own kind
    assert_reject_flag_R8: assert property (@(posedge clk) disable iff (!rstN)
      (strobes.reject && strobes.rejKind == 2'(t)) |=> statusWord[4*t+1]);
  end

  assign irq = |statusWord;

  always_comb begin
    busRdata = '0;
    if (busSel && !busWrite) begin
      case (busAddr)
        ADR_LVL0:  busRdata = {{(DATA_W-LEVEL_W){1'b0}}, levelCur[0]};
        ADR_LVL1:  busRdata = {{(DATA_W-LEVEL_W){1'b0}}, levelCur[1]};
        ADR_CMD:   busRdata = {cfgGo, cmdWr, {FUNC_GAP{1'b0}}, cmdFunc,
                               {DEV_GAP{1'b0}}, cmdDev};
        ADR_STAT:  busRdata = {{(DATA_W-STAT_W){1'b0}}, statusWord};
        ADR_WDATA: busRdata = wdataReg;
        ADR_RDATA: busRdata = rdataReg;
        ADR_INFO:  busRdata = {{INFO_PAD{1'b0}}, CNT_W'(CPUS1), CNT_W'(CPUS0),
                               {INFO_LSB{1'b0}}};
        default:   busRdata = '0;
      endcase
    end
  end

  // R10: payload held while the request waits
  assert_payload_stable_R10: assert property (@(posedge clk) disable iff (!rstN)
    (mcReq && !mcAck) |=> $stable({mcWrite, mcFunc, mcDevice, mcWdata}));

  // R7: a status read with no new event leaves the interrupt low
  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rdStat && !(|anySetVec)) |=> !irq);

  // R4: start readback drops after the acknowledge of a config transaction
  assert_go_clears_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && snapKind == KIND_CFG) |=> !cfgGo);
endmodule

// File: rtl/pwr_req_bridge.sv
module pwr_req_bridge
  import pwrb_pkg::*;
#(
  parameter int LEVEL_W = 3,
  parameter int CNT_W   = 4,
  parameter int CPUS0   = 4,
  parameter int CPUS1   = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busSel,
  input  logic        busWrite,
  input  logic [11:0] busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  output logic        irq,
  output logic        mcReq,
  output logic        mcWrite,
  output logic [1:0]  mcKind,
  output logic [5:0]  mcFunc,
  output logic [11:0] mcDevice,
  output logic [31:0] mcWdata,
  input  logic        mcAck,
  input  logic        mcErr,
  input  logic [31:0] mcRdata
);
  strobes_t strobes;
  logic     newReq;
  reqKind_e newKind;
  reqKind_e kindOut;

  pwrb_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .newReq(newReq), .newKind(newKind),
    .mcAck(mcAck), .mcErr(mcErr), .strobes(strobes),
    .mcReq(mcReq), .mcKind(kindOut)
  );

  pwrb_datapath #(
    .LEVEL_W(LEVEL_W), .CNT_W(CNT_W), .CPUS0(CPUS0), .CPUS1(CPUS1)
  ) dp_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irq(irq),
    .newReq(newReq), .newKind(newKind), .strobes(strobes), .mcReq(mcReq),
    .mcAck(mcAck), .mcErr(mcErr), .mcRdata(mcRdata), .mcWrite(mcWrite),
    .mcFunc(mcFunc), .mcDevice(mcDevice), .mcWdata(mcWdata)
  );

  assign mcKind = kindOut;
endmodule

// File: tb/pwr_req_bridge_tb_top.sv
module pwr_req_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWrite = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0, busRdata;
  logic        irq, mcReq, mcWrite;
  logic [1:0]  mcKind;
  logic [5:0]  mcFunc;
  logic [11:0] mcDevice;
  logic [31:0] mcWdata;
  logic        mcAck = 1'b0, mcErr = 1'b0;
  logic [31:0] mcRdata = '0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  pwr_req_bridge #(.CPUS0(2), .CPUS1(4)) dut_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irq(irq),
    .mcReq(mcReq), .mcWrite(mcWrite), .mcKind(mcKind), .mcFunc(mcFunc),
    .mcDevice(mcDevice), .mcWdata(mcWdata), .mcAck(mcAck), .mcErr(mcErr),
    .mcRdata(mcRdata)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 20000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic busWr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk); #1;
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  // read across a clock edge (status read clears)
  task automatic busRd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    #2 d = busRdata;
    @(posedge clk); #1;
    busSel = 1'b0;
  endtask

  // read between edges, no clock edge crossed
  task automatic peek(input logic [11:0] a, output logic [31:0] d);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    #2 d = busRdata;
    #1 busSel = 1'b0;
  endtask

  task automatic mcRespond(input logic err, input logic [31:0] rd);
    @(negedge clk);
    check("R10", "mcReq before ack", 32'(mcReq), 32'd1);
    mcAck = 1'b1; mcErr = err; mcRdata = rd;
    @(posedge clk); #1;
    mcAck = 1'b0; mcErr = 1'b0;
  endtask

  task automatic testReset();
    logic [31:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    check("R1", "irq", 32'(irq), 32'd0);
    check("R1", "mcReq", 32'(mcReq), 32'd0);
    peek(12'hB18, v); check("R1", "status", v, 32'd0);
    peek(12'hB00, v); check("R1", "level0", v, 32'd0);
    peek(12'hB10, v); check("R1", "cmd", v, 32'd0);
    peek(12'hB74, v); check("R1", "rdata", v, 32'd0);
  endtask

  task automatic testPerfOk();
    logic [31:0] v;
    busWr(12'hB00, 32'hFFFF_FFF5);
    @(negedge clk);
    check("R2", "mcReq", 32'(mcReq), 32'd1);
    check("R2", "mcKind", 32'(mcKind), 32'd0);
    check("R2", "mcWrite", 32'(mcWrite), 32'd1);
    check("R2", "mcWdata", mcWdata, 32'd5);
    peek(12'hB00, v); check("R2", "old level", v, 32'd0);
    mcRespond(1'b0, 32'h0);
    @(negedge clk);
    check("R7", "irq before post", 32'(irq), 32'd0);
    @(negedge clk);
    check("R7", "irq after post", 32'(irq), 32'd1);
    check("R2", "mcReq released", 32'(mcReq), 32'd0);
    peek(12'hB00, v); check("R2", "new level", v, 32'd5);
    busRd(12'hB18, v); check("R6", "status complete kind0", v, 32'h1);
    @(negedge clk);
    check("R7", "irq cleared", 32'(irq), 32'd0);
    peek(12'hB18, v); check("R7", "status cleared", v, 32'd0);
  endtask

  task automatic testPerfErr();
    logic [31:0] v;
    busWr(12'hB08, 32'd6);
    @(negedge clk);
    check("R2", "mcKind cluster1", 32'(mcKind), 32'd1);
    mcRespond(1'b1, 32'h0);
    @(negedge clk); @(negedge clk);
    peek(12'hB18, v); check("R6", "status error kind1", v, 32'h20);
    peek(12'hB08, v); check("R6", "level1 unchanged", v, 32'd0);
    busRd(12'hB18, v);
  endtask

  task automatic testCfgWrite();
    logic [31:0] v;
    busWr(12'hB70, 32'h1234_5678);
    peek(12'hB70, v); check("R3", "wdata readback", v, 32'h1234_5678);
    busWr(12'hB10, 32'hC2A0_0ABC);
    @(negedge clk);
    check("R3", "mcKind", 32'(mcKind), 32'd2);
    check("R3", "mcWrite", 32'(mcWrite), 32'd1);
    check("R3", "mcFunc", 32'(mcFunc), 32'h2A);
    check("R3", "mcDevice", 32'(mcDevice), 32'hABC);
    check("R3", "mcWdata", mcWdata, 32'h1234_5678);
    peek(12'hB10, v); check("R4", "go readback busy", v, 32'hC2A0_0ABC);
    busWr(12'hB70, 32'hDEAD_0000);
    repeat (3) @(negedge clk);
    check("R10", "mcReq held", 32'(mcReq), 32'd1);
    check("R10", "mcWdata held", mcWdata, 32'h1234_5678);
    check("R10", "mcFunc held", 32'(mcFunc), 32'h2A);
    mcRespond(1'b0, 32'h0);
    @(negedge clk);
    peek(12'hB10, v); check("R4", "go cleared", v, 32'h42A0_0ABC);
    @(negedge clk);
    busRd(12'hB18, v); check("R6", "status complete kind2", v, 32'h100);
  endtask

  task automatic testCfgRead();
    logic [31:0] v;
    busWr(12'hB10, 32'h8010_0055);
    @(negedge clk);
    check("R3", "read mcWrite", 32'(mcWrite), 32'd0);
    mcRespond(1'b0, 32'hCAFE_F00D);
    @(negedge clk);
    peek(12'hB74, v); check("R5", "rdata before status", v, 32'hCAFE_F00D);
    check("R5", "irq still low", 32'(irq), 32'd0);
    @(negedge clk);
    check("R5", "irq after post", 32'(irq), 32'd1);
    busRd(12'hB18, v); check("R5", "status complete", v, 32'h100);
  endtask

  task automatic testReject();
    logic [31:0] v;
    busWr(12'hB10, 32'h8030_0010);
    busWr(12'hB08, 32'd3);
    @(negedge clk);
    check("R8", "outstanding kind kept", 32'(mcKind), 32'd2);
    check("R8", "mcReq still up", 32'(mcReq), 32'd1);
    peek(12'hB18, v); check("R8", "reject error bit", v, 32'h20);
    check("R7", "irq on reject", 32'(irq), 32'd1);
    mcRespond(1'b0, 32'h0BAD_F00D);
    @(negedge clk); @(negedge clk);
    peek(12'hB18, v); check("R8", "both bits", v, 32'h120);
    peek(12'hB08, v); check("R8", "level1 not forwarded", v, 32'd0);
    peek(12'hB74, v); check("R8", "original read data", v, 32'h0BAD_F00D);
    busRd(12'hB18, v);
  endtask

  task automatic testNoStart();
    logic [31:0] v;
    busWr(12'hB10, 32'h4050_0007);
    @(negedge clk);
    check("R3", "no request", 32'(mcReq), 32'd0);
    peek(12'hB10, v); check("R3", "fields stored", v, 32'h4050_0007);
    peek(12'hB18, v); check("R3", "status untouched", v, 32'd0);
  endtask

  task automatic testInfo();
    logic [31:0] v;
    @(negedge clk);
    peek(12'h700, v); check("R9", "cluster info", v, 32'h0042_0000);
    peek(12'h004, v); check("R9", "unmapped", v, 32'd0);
  endtask

  initial begin
    testReset();
    testPerfOk();
    testPerfErr();
    testCfgWrite();
    testCfgRead();
    testReject();
    testNoStart();
    testInfo();
    repeat (2) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule